// File: doc/BRIEF.md
# Broadcast-Input Multiply-Accumulate Array

This block is a row of identical multiply-accumulate units driven by one shared controller. On each accepted beat, every unit receives the same signed 8-bit sample and a signed 8-bit weight of its own, taken from a wide weight bus that carries one weight per unit. Each unit multiplies the two values, sign-extends the product to 32 bits and adds it to a private running sum. Additions wrap at 32 bits.

A layer mode sets how many beats make up one group. The dense mode uses 512 beats, the wide mode uses 1024 and the fused-convolution mode uses 256. When the final beat of a group is accepted, the sums of all units are copied together to the result bus. The next accepted beat starts a fresh group with no idle cycle between the two.

The result set waits on a valid/ready handshake. While a result set is waiting, input is stalled. The controller is a two-state machine. GS_IDLE means no group is open. The transition "first beat" takes it to GS_ACCUM, where beats are counted. The transition "final beat" returns it to GS_IDLE. A mode can change only in GS_IDLE. A request made in GS_ACCUM is held until the machine is back in GS_IDLE.

Top module: `bmac_array`

## Requirements
- R1: After reset, res_valid is 0, in_ready is 1 and cur_mode is 2'b00, which is the dense mode.
- R2: Unit i uses in_weights[8*i +: 8] as its weight and reports on res_sums[32*i +: 32]. Its sum is the total of the signed products of in_sample and that weight over the group, each product sign-extended to 32 bits.
- R3: A result set is produced after exactly 512 accepted beats when cur_mode is 2'b00, after 1024 when it is 2'b01, and after 256 when it is 2'b10.
- R4: A beat is accepted only on a cycle where in_valid and in_ready are both 1. Cycles without an accepted beat leave every sum unchanged.
- R5: res_valid rises in the cycle after the final beat of a group. An accepted beat in that same cycle opens the next group, which starts from zero.
- R6: While res_valid is 1 and res_ready is 0, res_valid and res_sums hold their values and in_ready is 0. When res_valid is 0 or res_ready is 1, in_ready is 1.
- R7: A mode request (mode_set pulsed with mode_sel) made while no group is open shows on cur_mode in the next cycle, and the group that begins on that cycle uses the new mode.
- R8: A request made while a group is open leaves cur_mode unchanged until the group completes. It is applied in the first cycle after the group ends. If several requests arrive during one group, the last one wins.
- R9: The code 2'b11 is ignored. It neither changes cur_mode nor replaces a request that is being held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_set | input | 1 | Pulse that requests a layer mode change |
| mode_sel | input | 2 | Requested mode: 00 dense, 01 wide, 10 fused convolution, 11 ignored |
| cur_mode | output | 2 | Layer mode currently in effect |
| in_valid | input | 1 | The input sample and weights are present |
| in_ready | output | 1 | The array can accept a beat |
| in_sample | input | IN_W (8) | Signed sample broadcast to all units |
| in_weights | input | N_UNITS*IN_W (64) | One signed weight per unit |
| res_valid | output | 1 | A result set is waiting |
| res_ready | input | 1 | The consumer takes the result set |
| res_sums | output | N_UNITS*ACC_W (256) | One 32-bit sum per unit |

## Verification
On every cycle, the assertions check three things. A beat that completes the depth chosen by the current mode raises res_valid. cur_mode never moves while a group is open and never takes the ignored code. A result set that is waiting holds still and stalls the input. Only the bench's scenarios can show the arithmetic of the sums with mixed signs and extreme operands. They also show that a request held during a group lands at the group boundary, that a later request replaces an earlier one, and that groups follow each other without a gap under random stalls from both the input and the consumer.

// File: rtl/bmac_pkg.sv
package bmac_pkg;

    typedef enum logic [1:0] {
        LM_DENSE = 2'b00,
        LM_WIDE  = 2'b01,
        LM_CONV  = 2'b10,
        LM_RSVD  = 2'b11
    } layer_mode_e;

    typedef enum logic {
        GS_IDLE  = 1'b0,
        GS_ACCUM = 1'b1
    } grp_state_e;

endpackage

// File: rtl/bmac_unit.sv
module bmac_unit #(
    parameter int IN_W  = 8,
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load,
    input  logic [IN_W-1:0]  x,
    input  logic [IN_W-1:0]  w,
    output logic [ACC_W-1:0] sum_nxt
);
    localparam int PW = 2 * IN_W;

    logic signed [PW-1:0] prod;
    logic [ACC_W-1:0]     prod_ext;
    logic [ACC_W-1:0]     acc_q;

    always_comb begin
        prod     = $signed(x) * $signed(w);
        prod_ext = {{(ACC_W-PW){prod[PW-1]}}, prod};
        sum_nxt  = load ? prod_ext : (acc_q + prod_ext);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= sum_nxt;
        end
    end

endmodule

// File: rtl/bmac_ctrl.sv
module bmac_ctrl
    import bmac_pkg::*;
#(
    parameter int DEPTH_DENSE = 512,
    parameter int DEPTH_WIDE  = 1024,
    parameter int DEPTH_CONV  = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_set,
    input  logic [1:0] mode_sel,
    input  logic       beat,
    output logic       first_beat,
    output logic       last_beat,
    output logic [1:0] cur_mode
);
    localparam int MAX_AB = (DEPTH_DENSE > DEPTH_WIDE) ? DEPTH_DENSE : DEPTH_WIDE;
    localparam int MAX_D  = (MAX_AB > DEPTH_CONV) ? MAX_AB : DEPTH_CONV;
    localparam int CNT_W  = $clog2(MAX_D);

    grp_state_e  state_q, state_d;
    layer_mode_e mode_q, pend_mode_q;
    logic        pend_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] depth_m1;
    logic        req_ok;

    assign req_ok = mode_set && (mode_sel != LM_RSVD);

    always_comb begin
        unique case (mode_q)
            LM_WIDE: depth_m1 = CNT_W'(DEPTH_WIDE - 1);
            LM_CONV: depth_m1 = CNT_W'(DEPTH_CONV - 1);
            default: depth_m1 = CNT_W'(DEPTH_DENSE - 1);
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_IDLE:  if (beat) state_d = GS_ACCUM;
            GS_ACCUM: if (beat && (cnt_q == depth_m1)) state_d = GS_IDLE;
            default:  state_d = GS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        first_beat = 1'b0;
        last_beat  = 1'b0;
        unique case (state_q)
            GS_IDLE:  first_beat = beat;
            GS_ACCUM: last_beat  = beat && (cnt_q == depth_m1);
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (first_beat) begin
            cnt_q <= CNT_W'(1);
        end else if (last_beat) begin
            cnt_q <= '0;
        end else if (beat) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q      <= LM_DENSE;
            pend_q      <= 1'b0;
            pend_mode_q <= LM_DENSE;
        end else if (state_q == GS_IDLE) begin
            if (req_ok) begin
                mode_q <= layer_mode_e'(mode_sel);
            end else if (pend_q) begin
                mode_q <= pend_mode_q;
            end
            pend_q <= 1'b0;
        end else if (req_ok) begin
            pend_q      <= 1'b1;
            pend_mode_q <= layer_mode_e'(mode_sel);
        end
    end

    assign cur_mode = mode_q;

endmodule

// File: rtl/bmac_array.sv
module bmac_array #(
    parameter int N_UNITS     = 8,
    parameter int IN_W        = 8,
    parameter int ACC_W       = 32,
    parameter int DEPTH_DENSE = 512,
    parameter int DEPTH_WIDE  = 1024,
    parameter int DEPTH_CONV  = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_set,
    input  logic [1:0]               mode_sel,
    output logic [1:0]               cur_mode,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [IN_W-1:0]          in_sample,
    input  logic [N_UNITS*IN_W-1:0]  in_weights,
    output logic                     res_valid,
    input  logic                     res_ready,
    output logic [N_UNITS*ACC_W-1:0] res_sums
);
    localparam int RES_W = N_UNITS * ACC_W;

    logic             beat, first_beat, last_beat;
    logic             res_valid_q;
    logic [RES_W-1:0] res_q;
    logic [RES_W-1:0] sums_nxt;

    assign in_ready = !res_valid_q || res_ready;
    assign beat     = in_valid && in_ready;

    bmac_ctrl #(
        .DEPTH_DENSE(DEPTH_DENSE),
        .DEPTH_WIDE (DEPTH_WIDE),
        .DEPTH_CONV (DEPTH_CONV)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_set  (mode_set),
        .mode_sel  (mode_sel),
        .beat      (beat),
        .first_beat(first_beat),
        .last_beat (last_beat),
        .cur_mode  (cur_mode)
    );

    for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
        bmac_unit #(
            .IN_W (IN_W),
            .ACC_W(ACC_W)
        ) u_mac (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (beat),
            .load   (first_beat),
            .x      (in_sample),
            .w      (in_weights[i*IN_W +: IN_W]),
            .sum_nxt(sums_nxt[i*ACC_W +: ACC_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid_q <= 1'b0;
            res_q       <= '0;
        end else begin
            if (last_beat) begin
                res_valid_q <= 1'b1;
                res_q       <= sums_nxt;
            end else if (res_ready) begin
                res_valid_q <= 1'b0;
            end
        end
    end

    assign res_valid = res_valid_q;
    assign res_sums  = res_q;

endmodule

// File: rtl/bmac_array_chk.sv
module bmac_array_chk #(
    parameter int N_UNITS     = 8,
    parameter int ACC_W       = 32,
    parameter int DEPTH_DENSE = 512,
    parameter int DEPTH_WIDE  = 1024,
    parameter int DEPTH_CONV  = 256
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               cur_mode,
    input logic                     in_valid,
    input logic                     in_ready,
    input logic                     res_valid,
    input logic                     res_ready,
    input logic [N_UNITS*ACC_W-1:0] res_sums
);
    logic [15:0] c_cnt;
    int          dep;
    logic        c_beat;
    logic        c_done;

    always_comb begin
        case (cur_mode)
            2'b01:   dep = DEPTH_WIDE;
            2'b10:   dep = DEPTH_CONV;
            default: dep = DEPTH_DENSE;
        endcase
        c_beat = in_valid && in_ready;
        c_done = c_beat && (c_cnt != 16'd0) && (32'(c_cnt) == dep - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_cnt <= '0;
        end else if (c_beat) begin
            c_cnt <= c_done ? 16'd0 : c_cnt + 16'd1;
        end
    end

    a_r3_depth_done: assert property (@(posedge clk) disable iff (!rst_n)
        c_done |=> res_valid);

    a_r8_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (c_cnt != 16'd0) |=> $stable(cur_mode));

    a_r9_no_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
        cur_mode != 2'b11);

    a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_sums)));

    a_r6_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |-> !in_ready);

endmodule

bind bmac_array bmac_array_chk #(
    .N_UNITS    (N_UNITS),
    .ACC_W      (ACC_W),
    .DEPTH_DENSE(DEPTH_DENSE),
    .DEPTH_WIDE (DEPTH_WIDE),
    .DEPTH_CONV (DEPTH_CONV)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_mode (cur_mode),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .res_valid(res_valid),
    .res_ready(res_ready),
    .res_sums (res_sums)
);

// File: tb/sim_bmac_array.sv
module sim_bmac_array;
    localparam int N  = 4;
    localparam int RW = N * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_set = 1'b0;
    logic [1:0]    mode_sel = 2'b00;
    logic [1:0]    cur_mode;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [7:0]    in_sample = '0;
    logic [N*8-1:0] in_weights = '0;
    logic          res_valid;
    logic          res_ready = 1'b1;
    logic [RW-1:0] res_sums;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bmac_array #(.N_UNITS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_set(mode_set), .mode_sel(mode_sel),
        .cur_mode(cur_mode), .in_valid(in_valid), .in_ready(in_ready),
        .in_sample(in_sample), .in_weights(in_weights), .res_valid(res_valid),
        .res_ready(res_ready), .res_sums(res_sums)
    );

    // behavioural reference model
    int          m_cnt, m_mode, m_pmode;
    bit          m_pend, m_rv;
    int          m_acc [N];
    logic [RW-1:0] m_res;

    function automatic int depth_of(int m);
        if (m == 1) return 1024;
        if (m == 2) return 256;
        return 512;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_mode = 0; m_pmode = 0; m_pend = 0; m_rv = 0; m_res = '0;
            for (int i = 0; i < N; i++) m_acc[i] = 0;
        end else begin
            bit bt;
            bt = in_valid && (!m_rv || res_ready);
            if (m_rv && res_ready) m_rv = 0;
            if (m_cnt == 0) begin
                if (mode_set && mode_sel != 2'b11) m_mode = int'(mode_sel);
                else if (m_pend) m_mode = m_pmode;
                m_pend = 0;
            end else if (mode_set && mode_sel != 2'b11) begin
                m_pend = 1; m_pmode = int'(mode_sel);
            end
            if (bt) begin
                for (int i = 0; i < N; i++) begin
                    int p;
                    p = int'($signed(in_sample)) * int'($signed(in_weights[i*8 +: 8]));
                    m_acc[i] = (m_cnt == 0) ? p : m_acc[i] + p;
                end
                m_cnt++;
                if (m_cnt == depth_of(m_mode)) begin
                    for (int i = 0; i < N; i++) m_res[i*32 +: 32] = m_acc[i];
                    m_rv = 1; m_cnt = 0;
                end
            end
        end
    end

    string tag_ir = "R6", tag_rv = "R3", tag_mode = "R7", tag_sum = "R2";

    task automatic chk(string tag, logic [RW-1:0] act, logic [RW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(tag_ir, RW'(in_ready), RW'(!m_rv || res_ready));
        chk(tag_rv, RW'(res_valid), RW'(m_rv));
        chk(tag_mode, RW'(cur_mode), RW'(m_mode));
        if (m_rv) chk(tag_sum, res_sums, m_res);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    function automatic logic [7:0] pick(int kind);
        if (kind == 1) begin
            case ($urandom % 4)
                0: return 8'h80;
                1: return 8'h7f;
                2: return 8'hff;
                default: return 8'h00;
            endcase
        end
        return 8'($urandom);
    endfunction

    task automatic drive(int pv, int pr, int kind);
        in_valid  = ($urandom % 100) < pv;
        res_ready = ($urandom % 100) < pr;
        in_sample = pick(kind);
        for (int i = 0; i < N; i++) in_weights[i*8 +: 8] = pick(kind);
    endtask

    task automatic run(int cycles, int pv, int pr, int kind);
        for (int c = 0; c < cycles; c++) begin
            drive(pv, pr, kind);
            step();
        end
    endtask

    task automatic req(logic [1:0] m);
        mode_set = 1'b1;
        mode_sel = m;
        drive(100, 100, 0);
        step();
        mode_set = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", RW'(res_valid), RW'(0));
        chk("R1", RW'(in_ready), RW'(1));
        chk("R1", RW'(cur_mode), RW'(0));

        // dense groups, steady input: groups back to back
        tag_rv = "R5";
        run(1100, 100, 100, 0);
        // gaps in the input stream
        tag_rv = "R3"; tag_sum = "R4";
        run(1200, 50, 100, 0);
        tag_sum = "R2";

        // mid-group requests: held, last wins, reserved ignored
        while (m_cnt < 5) run(1, 100, 100, 0);
        tag_mode = "R8";
        req(2'b01);
        run(10, 100, 100, 0);
        req(2'b10);
        tag_mode = "R9";
        req(2'b11);
        tag_mode = "R8";
        run(600, 100, 100, 0);

        // idle requests
        in_valid = 1'b0;
        while (m_cnt != 0) run(1, 100, 100, 0);
        in_valid = 1'b0; res_ready = 1'b1;
        step();
        tag_mode = "R9";
        mode_set = 1'b1; mode_sel = 2'b11; step();
        mode_set = 1'b0; step();
        tag_mode = "R7";
        mode_set = 1'b1; mode_sel = 2'b01; step();
        mode_set = 1'b0;
        run(1100, 100, 100, 0);
        while (m_cnt != 0) run(1, 100, 100, 0);
        mode_set = 1'b1; mode_sel = 2'b10; in_valid = 1'b0; step();
        mode_set = 1'b0;

        // consumer backpressure in fused-convolution mode
        tag_ir = "R6";
        run(1500, 100, 30, 0);
        // extreme operands
        run(800, 90, 80, 1);
        run(300, 100, 100, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule